// File: doc/BRIEF.md
# Indexed Extra-Operand Register File

This block is a small register file that gives an accelerator pipeline more inputs than the two source operands a normal operation request carries. Before the accelerator operation is issued, a short run of move commands stages the extra operands in the file. Per-stage control logic in the accelerator then reads the stored values back through combinational read ports.

There are three move commands. A single move writes one word to an address named in the command. A pair move with restart writes two words to entries 0 and 1 and restarts an internal fill pointer at 2. A pair move with append writes two words at the fill pointer and advances it by two. With these, a compact instruction sequence can load any number of operands without naming an address in each command.

An append that would run past the last entry is dropped, and a sticky overflow flag reports it. Depth, word width and the number of read ports are parameters. Depth is a power of two, typically 8, or 16 for larger accelerators.

Top module: `xop_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every entry is cleared to zero, the fill pointer returns to 0 and `ovf` goes low.
- R2: Opcode 1 (single move) writes `cmd_a` into the entry named by `cmd_addr` and leaves the fill pointer unchanged.
- R3: Opcode 2 (pair move with restart) writes `cmd_a` to entry 0 and `cmd_b` to entry 1, sets the fill pointer to 2 and clears `ovf`.
- R4: Opcode 3 (pair move with append) writes `cmd_a` to the entry at the fill pointer and `cmd_b` to the next entry, then advances the pointer by 2.
- R5: An opcode 3 issued when the pointer is greater than DEPTH-2 changes no entry and does not move the pointer. It sets `ovf`, which stays high until the next opcode 2 or reset; other opcodes do not clear it.
- R6: Each read port returns the entry at its address in the same cycle. A write becomes visible only after the clock edge, so a read of an entry being written in that cycle returns the old value.
- R7: Opcode 0 changes no entry, does not move the pointer and does not change `ovf`.
- R8: Each read port is addressed independently of the others. Port p uses bits [p*AW +: AW] of `rd_addr` and bits [p*WIDTH +: WIDTH] of `rd_data`.
- R9: An append with no earlier restart since reset starts at entry 0, because reset leaves the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 2 | 0 none, 1 single move, 2 pair move with restart, 3 pair move with append |
| cmd_a | input | WIDTH | First data word (the only one used by a single move) |
| cmd_b | input | WIDTH | Second data word for the pair moves |
| cmd_addr | input | AW | Target entry of a single move (AW = log2 DEPTH) |
| rd_addr | input | RD_PORTS*AW | Read addresses, one field per port |
| rd_data | output | RD_PORTS*WIDTH | Read data, one field per port, combinational |
| ovf | output | 1 | Sticky flag: an append was dropped for lack of room |

## Verification
The bench drives the file to its fill limit. A design that compares the pointer against the wrong bound would either drop the last legal pair (entries DEPTH-2 and DEPTH-1) or wrap around and overwrite entries 0 and 1. It checks that a single move between appends leaves the pointer in place; a design that advances it there would leave a one-entry gap in the next append. It checks that `ovf` survives single moves, idle cycles and further dropped appends and is cleared only by a restart or by reset. It also reads a target entry before the edge that writes it, which exposes a design that forwards write data combinationally.

// File: rtl/xop_pkg.sv
// Package: shared command encoding for the extra-operand register file.
// Assumes a 2-bit opcode field supplied by the instruction decoder.
package xop_pkg;
    typedef enum logic [1:0] {
        XOP_NOP      = 2'd0,
        XOP_PUT      = 2'd1,
        XOP_PAIR_RST = 2'd2,
        XOP_PAIR_APP = 2'd3
    } xop_cmd_e;
endpackage

// File: rtl/xop_fill_ctrl.sv
// Fill controller: owns the fill pointer and the overflow flag, and turns
// one command into up to two write requests for the storage array.
// Assumes DEPTH is a power of two and at least 2.
module xop_fill_ctrl
    import xop_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xop_cmd_e         op,
    input  logic [WIDTH-1:0] word_a,
    input  logic [WIDTH-1:0] word_b,
    input  logic [AW-1:0]    put_addr,
    output logic             wr0_en,
    output logic [AW-1:0]    wr0_addr,
    output logic [WIDTH-1:0] wr0_data,
    output logic             wr1_en,
    output logic [AW-1:0]    wr1_addr,
    output logic [WIDTH-1:0] wr1_data,
    output logic             ovf
);
    localparam logic [IW:0] LIMIT = (IW+1)'(DEPTH);

    logic [IW-1:0] idx_q;
    logic [IW:0]   idx_plus2;
    logic          has_room;
    logic          app_ok;
    logic          app_drop;

    // Room test: the append pair must end at or before the last entry.
    always_comb begin
        idx_plus2 = {1'b0, idx_q} + (IW+1)'(2);
        has_room  = (idx_plus2 <= LIMIT);
        app_ok    = (op == XOP_PAIR_APP) && has_room;
        app_drop  = (op == XOP_PAIR_APP) && !has_room;
    end

    // Write request steering for the three move kinds.
    always_comb begin
        wr0_en   = 1'b0;
        wr0_addr = '0;
        wr0_data = word_a;
        wr1_en   = 1'b0;
        wr1_addr = '0;
        wr1_data = word_b;
        case (op)
            XOP_PUT: begin
                wr0_en   = 1'b1;
                wr0_addr = put_addr;
            end
            XOP_PAIR_RST: begin
                wr0_en   = 1'b1;
                wr0_addr = AW'(0);
                wr1_en   = 1'b1;
                wr1_addr = AW'(1);
            end
            XOP_PAIR_APP: begin
                wr0_en   = app_ok;
                wr0_addr = idx_q[AW-1:0];
                wr1_en   = app_ok;
                wr1_addr = idx_q[AW-1:0] + AW'(1);
            end
            default: ;
        endcase
    end

    // Fill pointer: restart at 2, advance by 2 on an accepted append.
    always_ff @(posedge clk) begin
        if (!rst_n)                  idx_q <= '0;
        else if (op == XOP_PAIR_RST) idx_q <= IW'(2);
        else if (app_ok)             idx_q <= idx_plus2[IW-1:0];
    end

    // Sticky overflow flag: set by a dropped append, cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf <= 1'b0;
        else if (op == XOP_PAIR_RST) ovf <= 1'b0;
        else if (app_drop)           ovf <= 1'b1;
    end

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == XOP_PAIR_RST) |=> (idx_q == IW'(2)) && !ovf);

    p_append_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == XOP_PAIR_APP && idx_q <= IW'(DEPTH-2)) |=> (idx_q == $past(idx_q) + IW'(2)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == XOP_PAIR_APP && idx_q > IW'(DEPTH-2)) |=> $stable(idx_q) && ovf);

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && op != XOP_PAIR_RST) |=> ovf);

    p_put_keeps_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == XOP_PUT || op == XOP_NOP) |=> $stable(idx_q));

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q <= IW'(DEPTH)) && !idx_q[0]);
endmodule

// File: rtl/xop_store.sv
// Storage array: DEPTH words with two write ports that take effect on the
// clock edge. Assumes the two ports never name the same entry in one cycle.
module xop_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr0_en,
    input  logic [AW-1:0]               wr0_addr,
    input  logic [WIDTH-1:0]            wr0_data,
    input  logic                        wr1_en,
    input  logic [AW-1:0]               wr1_addr,
    input  logic [WIDTH-1:0]            wr1_data,
    output logic [DEPTH-1:0][WIDTH-1:0] entries
);
    // One register per entry, each with its own write decode.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Entry update: clear on reset, otherwise take whichever port hits it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entries[e] <= '0;
            else if (wr0_en && wr0_addr == AW'(e))
                entries[e] <= wr0_data;
            else if (wr1_en && wr1_addr == AW'(e))
                entries[e] <= wr1_data;
        end
    end

    p_port_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && wr1_en) |-> (wr0_addr != wr1_addr));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr0_en |=> (entries[$past(wr0_addr)] == $past(wr0_data)));
endmodule

// File: rtl/xop_rd_mux.sv
// Read selector: one combinational multiplexer per accelerator stage port.
// Assumes the address fields are packed port 0 in the low bits.
module xop_rd_mux #(
    parameter int DEPTH    = 8,
    parameter int WIDTH    = 32,
    parameter int RD_PORTS = 2,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] entries,
    input  logic [RD_PORTS*AW-1:0]      rd_addr,
    output logic [RD_PORTS*WIDTH-1:0]   rd_data
);
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        logic [AW-1:0] sel;
        // Port selection: pick this port's address field and its entry.
        always_comb begin
            sel = rd_addr[p*AW +: AW];
            rd_data[p*WIDTH +: WIDTH] = entries[sel];
        end
    end
endmodule

// File: rtl/xop_regfile.sv
// Top: extra-operand register file for an accelerator pipeline. Accepts
// one move command per cycle and serves RD_PORTS combinational reads.
// Assumes DEPTH is a power of two; opcode encoding is in xop_pkg.
module xop_regfile
    import xop_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int WIDTH    = 32,
    parameter int RD_PORTS = 2,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cmd_op,
    input  logic [WIDTH-1:0]          cmd_a,
    input  logic [WIDTH-1:0]          cmd_b,
    input  logic [AW-1:0]             cmd_addr,
    input  logic [RD_PORTS*AW-1:0]    rd_addr,
    output logic [RD_PORTS*WIDTH-1:0] rd_data,
    output logic                      ovf
);
    xop_cmd_e                 op;
    logic                     wr0_en, wr1_en;
    logic [AW-1:0]            wr0_addr, wr1_addr;
    logic [WIDTH-1:0]         wr0_data, wr1_data;
    logic [DEPTH-1:0][WIDTH-1:0] entries;

    // Opcode decode into the shared command type.
    always_comb op = xop_cmd_e'(cmd_op);

    xop_fill_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .word_a   (cmd_a),
        .word_b   (cmd_b),
        .put_addr (cmd_addr),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data),
        .ovf      (ovf)
    );

    xop_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data),
        .entries  (entries)
    );

    xop_rd_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RD_PORTS(RD_PORTS)) u_rd (
        .entries (entries),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    p_nop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd0) |=> $stable(entries) && $stable(ovf));

    p_drop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd3 && !wr0_en) |=> $stable(entries));
endmodule

// File: tb/tb_xop_regfile.sv
`timescale 1ns/100ps
module tb_xop_regfile;
    localparam int DEPTH = 8;
    localparam int WIDTH = 32;
    localparam int RDP   = 2;
    localparam int AW    = $clog2(DEPTH);

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [1:0]            cmd_op;
    logic [WIDTH-1:0]      cmd_a, cmd_b;
    logic [AW-1:0]         cmd_addr;
    logic [RDP*AW-1:0]     rd_addr;
    logic [RDP*WIDTH-1:0]  rd_data;
    logic                  ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic [WIDTH-1:0] model [DEPTH];
    int               midx;
    bit               movf;

    xop_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RD_PORTS(RDP)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .cmd_addr(cmd_addr), .rd_addr(rd_addr), .rd_data(rd_data), .ovf(ovf)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        midx = 0;
        movf = 0;
    endtask

    // Model of one clock edge with the current command (R2 R3 R4 R5 R7).
    task automatic model_step(input logic [1:0] op, input logic [WIDTH-1:0] a,
                              input logic [WIDTH-1:0] b, input logic [AW-1:0] ad);
        case (op)
            2'd1: model[ad] = a;
            2'd2: begin model[0] = a; model[1] = b; midx = 2; movf = 0; end
            2'd3: begin
                if (midx + 2 <= DEPTH) begin
                    model[midx] = a; model[midx+1] = b; midx += 2;
                end else movf = 1;
            end
            default: ;
        endcase
    endtask

    // Sweep all entries through both ports (R8) and compare with the model.
    task automatic check_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr[0 +: AW]  = AW'(i);
            rd_addr[AW +: AW] = AW'(DEPTH-1-i);
            #0.2;
            chk(rd_data[0 +: WIDTH] == model[i], req, rd_data[0 +: WIDTH], model[i]);
            chk(rd_data[WIDTH +: WIDTH] == model[DEPTH-1-i], {req, "/R8"},
                rd_data[WIDTH +: WIDTH], model[DEPTH-1-i]);
        end
        chk(ovf == movf, {req, "/ovf"}, WIDTH'(ovf), WIDTH'(movf));
    endtask

    // Issue one command for one cycle, checking old-value read (R6) first.
    task automatic cmd(input logic [1:0] op, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input logic [AW-1:0] ad, input string req);
        int tgt;
        @(negedge clk);
        cmd_op = op; cmd_a = a; cmd_b = b; cmd_addr = ad;
        tgt = (op == 2'd1) ? int'(ad) : (op == 2'd2) ? 0 : (midx < DEPTH ? midx : 0);
        rd_addr[0 +: AW] = AW'(tgt);
        #0.2;
        chk(rd_data[0 +: WIDTH] == model[tgt], "R6 pre-edge old value",
            rd_data[0 +: WIDTH], model[tgt]);
        @(posedge clk);
        model_step(op, a, b, ad);
        #0.5;
        check_all(req);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_op = 2'd0;
        @(posedge clk);
        model_reset();
        #0.5;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_op = '0; cmd_a = '0; cmd_b = '0; cmd_addr = '0; rd_addr = '0;
        model_reset();
        // Dirty state first so reset has something to clear.
        @(negedge clk); rst_n = 1'b1;
        cmd(2'd2, 32'hAAAA_0001, 32'hAAAA_0002, '0, "R3 prefill");
        cmd(2'd1, 32'hAAAA_0007, '0, 3'd7, "R2 prefill");
        apply_reset();

        // R9: append straight after reset lands on entries 0 and 1.
        cmd(2'd3, 32'h1111_0000, 32'h1111_0001, '0, "R9 append from reset");
        cmd(2'd3, 32'h1111_0002, 32'h1111_0003, '0, "R4 append");

        // R2: single moves, pointer must stay at 4.
        cmd(2'd1, 32'h2222_0005, '0, 3'd5, "R2 put");
        cmd(2'd1, 32'h2222_0000, '0, 3'd0, "R2 put entry0");
        cmd(2'd3, 32'h3333_0004, 32'h3333_0005, '0, "R2/R4 append after put");

        // R7: idle cycles.
        cmd(2'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'd2, "R7 nop");

        // R3 restart then fill to the limit.
        cmd(2'd2, 32'h4444_0000, 32'h4444_0001, '0, "R3 restart");
        cmd(2'd3, 32'h4444_0002, 32'h4444_0003, '0, "R4 fill");
        cmd(2'd3, 32'h4444_0004, 32'h4444_0005, '0, "R4 fill");
        cmd(2'd3, 32'h4444_0006, 32'h4444_0007, '0, "R4 last legal pair");

        // R5: overflow, stickiness across other commands.
        cmd(2'd3, 32'h5555_0000, 32'h5555_0001, '0, "R5 dropped append");
        cmd(2'd1, 32'h5555_0003, '0, 3'd3, "R5 ovf holds over put");
        cmd(2'd0, '0, '0, '0, "R5 ovf holds over nop");
        cmd(2'd3, 32'h5555_0008, 32'h5555_0009, '0, "R5 second drop");
        cmd(2'd2, 32'h6666_0000, 32'h6666_0001, '0, "R3 restart clears ovf");

        // Overflow then reset clears it (R1).
        for (int k = 0; k < 4; k++)
            cmd(2'd3, 32'h7000_0000 + k, 32'h7100_0000 + k, '0, "R5 refill");
        apply_reset();

        // Random command stream against the model.
        for (int k = 0; k < 400; k++)
            cmd(2'($urandom_range(0, 3)), $urandom, $urandom, AW'($urandom_range(0, DEPTH-1)),
                "R2-mix random");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule